// File: doc/BRIEF.md
# Loopback Port Step Tester

This block checks an I/O port by running a fixed script of steps against an external loopback. In each step it drives its output lines to a set of levels. It then waits a settle count of clock cycles and samples the looped-back input lines through a two-stage synchroniser. Finally it compares only the lines that the step cares about against the levels the loopback should return. The outputs of a healthy port come back inverted on the inputs, so every drive has an inverted expectation.

Two scripts are built in, and `mode_i` picks one when a run starts. The tape script has eight steps. It covers the write/read pair, the motor line and a motor-sense line, and `sense_sel_i` chooses which of two sense inputs is the live one. The serial-bus script has seven steps. It covers a data pair, a clock pair, and a cross-line step in which the attention output must pull the clock input.

The run stops at the first step that fails. The result appears on an 8-bit status: the number of the failing step, or zero when every step passes. A controller pulses `start_i`, waits for `done_o` and then reads `status_o`.

Top module: `lpbk_step_tester`

## Requirements
- R1: A `start_i` seen while idle raises `busy_o` on the next cycle. `done_o` is a one-cycle pulse on the cycle in which `busy_o` falls. `start_i` while busy has no effect.
- R2: Each step holds its drive for settle+1 clock cycles, where settle is `settle_i` captured at start. The inputs are sampled at the end of the step through a two-flop synchroniser, so settle must be at least 2. A run that stops at step k keeps `busy_o` high for k*(settle+1) cycles.
- R3: Tape mode (`mode_i`=0) uses drive bit 0 as write and input bit 0 as read. Step 1 drives write low and expects read high. Step 2 drives write high and expects read low. Step 3 drives write low and expects read high.
- R4: In tape mode, steps 4 and 5 keep the motor off (drive bit 1 low). Step 4 expects the selected sense input low. Step 5 expects the motor readback (input bit 1) high.
- R5: Tape step 6 turns the motor on (drive bit 1 high) and expects the motor readback low.
- R6: `sense_sel_i`=0 selects the mapped sense input (input bit 2), and `sense_sel_i`=1 selects the port sense input (input bit 3). Tape step 7 expects bit 2 high only when bit 2 is selected. Tape step 8 expects bit 3 high only when bit 3 is selected. A step for the source that is not selected always passes, and the input that is not selected is ignored.
- R7: Serial mode (`mode_i`=1) uses drive bits 0/1/2 as DATA/CLK/ATN out and input bits 0/1 as DATA/CLK in. Step 1 drives all three low and expects both inputs high. Steps 2 and 3 drive DATA high then low and expect DATA-in low then high. Steps 4 and 5 do the same with CLK and CLK-in.
- R8: Serial steps 6 and 7 drive ATN high then low and expect CLK-in low then high.
- R9: The run ends at the first failing step, and `status_o` then equals that step number. `status_o` is zero after a full pass. It reads zero during a run and holds its value while idle.
- R10: Outside a run all drive lines are low. In serial mode, input bits 2 and 3 are ignored. At most one drive line is high at any time.
- R11: Mode, sense select and settle are captured at start. Changes to them during a run have no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a run (accepted while idle) |
| mode_i | input | 1 | Script select: 0 tape, 1 serial |
| sense_sel_i | input | 1 | Tape sense source: 0 input bit 2, 1 input bit 3 |
| settle_i | input | CNT_W | Settle cycles per step |
| lb_i | input | 4 | Looped-back input lines |
| drv_o | output | 3 | Drive lines to the port |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| status_o | output | 8 | First failing step, or zero on pass |

## Verification
Some rules are checked on every cycle: the handshake (busy follows an accepted start, done pulses exactly as busy falls), the status reading zero during a run and holding while idle, the bound on the status value, and the drive lines being idle-low and at most one-hot. Other behaviour only the bench scenarios can show. This covers which step a given loopback fault is reported at, the cross-line attention check, the choice of sense source, the skipped sense step, and the step timing for several settle counts. It also covers the fact that inputs changed mid-run are ignored. For this the bench injects stuck and open lines into a modelled loopback and compares the outputs against a behavioural model on every cycle.

// File: rtl/lpst_pkg.sv
package lpst_pkg;
  localparam int DRV_W     = 3;
  localparam int SNS_W     = 4;
  localparam int STEP_W    = 4;
  localparam int STAT_W    = 8;
  localparam int TAPE_LAST = 8;
  localparam int SER_LAST  = 7;

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_st_e;

  typedef struct packed {
    logic [DRV_W-1:0] drv;
    logic [SNS_W-1:0] want;
    logic [SNS_W-1:0] care;
  } step_t;

  function automatic step_t mk_step(logic [DRV_W-1:0] d, logic [SNS_W-1:0] w,
                                    logic [SNS_W-1:0] c);
    step_t s;
    s.drv  = d;
    s.want = w;
    s.care = c;
    return s;
  endfunction
endpackage

// File: rtl/lpst_sync.sv
module lpst_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/lpst_timer.sv
module lpst_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) cnt_d = load_val_i;
    else if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/lpst_script.sv
module lpst_script
  import lpst_pkg::*;
(
  input  logic              mode_i,
  input  logic              sel_i,
  input  logic [STEP_W-1:0] step_i,
  output step_t             entry_o,
  output logic              last_o
);
  // Tape:   drv[0]=write drv[1]=motor on; in[0]=read in[1]=motor readback
  //         in[2]=mapped sense in[3]=port sense
  // Serial: drv[0]=DATA drv[1]=CLK drv[2]=ATN; in[0]=DATA-in in[1]=CLK-in
  always_comb begin
    entry_o = mk_step('0, '0, '0);
    if (mode_i) begin
      unique case (step_i)
        4'd1: entry_o = mk_step(3'b000, 4'b0011, 4'b0011);
        4'd2: entry_o = mk_step(3'b001, 4'b0000, 4'b0001);
        4'd3: entry_o = mk_step(3'b000, 4'b0001, 4'b0001);
        4'd4: entry_o = mk_step(3'b010, 4'b0000, 4'b0010);
        4'd5: entry_o = mk_step(3'b000, 4'b0010, 4'b0010);
        4'd6: entry_o = mk_step(3'b100, 4'b0000, 4'b0010);
        4'd7: entry_o = mk_step(3'b000, 4'b0010, 4'b0010);
        default: entry_o = mk_step('0, '0, '0);
      endcase
    end else begin
      unique case (step_i)
        4'd1: entry_o = mk_step(3'b000, 4'b0001, 4'b0001);
        4'd2: entry_o = mk_step(3'b001, 4'b0000, 4'b0001);
        4'd3: entry_o = mk_step(3'b000, 4'b0001, 4'b0001);
        4'd4: entry_o = mk_step(3'b000, 4'b0000, sel_i ? 4'b1000 : 4'b0100);
        4'd5: entry_o = mk_step(3'b000, 4'b0010, 4'b0010);
        4'd6: entry_o = mk_step(3'b010, 4'b0000, 4'b0010);
        4'd7: entry_o = mk_step(3'b010, 4'b0100, sel_i ? 4'b0000 : 4'b0100);
        4'd8: entry_o = mk_step(3'b010, 4'b1000, sel_i ? 4'b1000 : 4'b0000);
        default: entry_o = mk_step('0, '0, '0);
      endcase
    end
  end

  assign last_o = (step_i == (mode_i ? STEP_W'(SER_LAST) : STEP_W'(TAPE_LAST)));
endmodule

// File: rtl/lpst_seq.sv
module lpst_seq
  import lpst_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              sel_i,
  input  logic [CNT_W-1:0]  settle_i,
  input  logic              expired_i,
  input  logic [SNS_W-1:0]  sense_i,
  input  step_t             entry_i,
  input  logic              last_i,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [STEP_W-1:0] step_o,
  output logic              mode_o,
  output logic              sel_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [STAT_W-1:0] status_o
);
  seq_st_e            st_q, st_d;
  logic [STEP_W-1:0]  step_q, step_d;
  logic [STAT_W-1:0]  status_q, status_d;
  logic               done_q, done_d;
  logic               mode_q, sel_q;
  logic [CNT_W-1:0]   settle_q;
  logic               cfg_en, status_en, step_pass;

  assign step_pass = (((sense_i ^ entry_i.want) & entry_i.care) == '0);

  always_comb begin
    st_d       = st_q;
    step_d     = step_q;
    status_d   = status_q;
    done_d     = 1'b0;
    cfg_en     = 1'b0;
    status_en  = 1'b0;
    load_o     = 1'b0;
    load_val_o = settle_q;
    unique case (st_q)
      SEQ_IDLE: begin
        if (start_i) begin
          st_d       = SEQ_RUN;
          step_d     = STEP_W'(1);
          status_d   = '0;
          status_en  = 1'b1;
          cfg_en     = 1'b1;
          load_o     = 1'b1;
          load_val_o = settle_i;
        end
      end
      SEQ_RUN: begin
        if (expired_i) begin
          if (!step_pass) begin
            st_d      = SEQ_IDLE;
            done_d    = 1'b1;
            status_d  = {{(STAT_W-STEP_W){1'b0}}, step_q};
            status_en = 1'b1;
          end else if (last_i) begin
            st_d      = SEQ_IDLE;
            done_d    = 1'b1;
            status_d  = '0;
            status_en = 1'b1;
          end else begin
            step_d = step_q + STEP_W'(1);
            load_o = 1'b1;
          end
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      sel_q    <= 1'b0;
      settle_q <= '0;
    end else if (cfg_en) begin
      mode_q   <= mode_i;
      sel_q    <= sel_i;
      settle_q <= settle_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (status_en) status_q <= status_d;
  end

  assign step_o   = step_q;
  assign mode_o   = mode_q;
  assign sel_o    = sel_q;
  assign busy_o   = (st_q == SEQ_RUN);
  assign done_o   = done_q;
  assign status_o = status_q;
endmodule

// File: rtl/lpbk_step_tester.sv
module lpbk_step_tester
  import lpst_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              sense_sel_i,
  input  logic [CNT_W-1:0]  settle_i,
  input  logic [SNS_W-1:0]  lb_i,
  output logic [DRV_W-1:0]  drv_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [STAT_W-1:0] status_o
);
  logic [SNS_W-1:0]  sense_s;
  logic              load, expired, last, mode_q, sel_q;
  logic [CNT_W-1:0]  load_val;
  logic [STEP_W-1:0] step;
  step_t             entry;

  lpst_sync #(.W(SNS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(lb_i), .dout(sense_s)
  );

  lpst_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(load_val),
    .expired_o(expired)
  );

  lpst_script u_script (
    .mode_i(mode_q), .sel_i(sel_q), .step_i(step), .entry_o(entry), .last_o(last)
  );

  lpst_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .sel_i(sense_sel_i), .settle_i(settle_i), .expired_i(expired),
    .sense_i(sense_s), .entry_i(entry), .last_i(last), .load_o(load),
    .load_val_o(load_val), .step_o(step), .mode_o(mode_q), .sel_o(sel_q),
    .busy_o(busy_o), .done_o(done_o), .status_o(status_o)
  );

  assign drv_o = busy_o ? entry.drv : '0;
endmodule

// File: rtl/lpst_checker.sv
module lpst_checker #(
  parameter int STAT_W = 8,
  parameter int DRV_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [STAT_W-1:0] status_o,
  input logic [DRV_W-1:0]  drv_o
);
  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_ends_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  p_fall_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  p_status_zero_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (status_o == '0));

  p_status_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(status_o));

  p_status_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (status_o <= STAT_W'(8)));

  p_idle_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (drv_o == '0));

  p_drive_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv_o));
endmodule

bind lpbk_step_tester lpst_checker #(.STAT_W(8), .DRV_W(3)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .status_o(status_o), .drv_o(drv_o)
);

// File: tb/sim_lpbk_step_tester.sv
module sim_lpbk_step_tester;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, mode_i, sense_sel_i;
  logic [15:0] settle_i;
  logic [3:0]  lb_i;
  logic [2:0]  drv_o;
  logic        busy_o, done_o;
  logic [7:0]  status_o;

  logic        harness;
  logic [3:0]  stuck0, stuck1;
  logic        atn_open;

  int checks = 0;
  int errors = 0;
  bit fin = 0;
  bit cmp_en = 0;

  always #5 clk = ~clk;

  lpbk_step_tester u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .sense_sel_i(sense_sel_i), .settle_i(settle_i), .lb_i(lb_i),
    .drv_o(drv_o), .busy_o(busy_o), .done_o(done_o), .status_o(status_o)
  );

  // Modelled external loopback with injectable faults
  function automatic logic [3:0] loop_fn(logic ser, logic [2:0] d, logic [3:0] s0,
                                         logic [3:0] s1, logic ao);
    logic [3:0] raw;
    if (ser) raw = {2'b00, ~(d[1] | (d[2] & ~ao)), ~d[0]};
    else     raw = {d[1], d[1], ~d[1], ~d[0]};
    return (raw & ~s0) | s1;
  endfunction

  assign lb_i = loop_fn(harness, drv_o, stuck0, stuck1, atn_open);

  // Behavioural reference: script expectations written from the requirements
  function automatic logic [2:0] m_drive(logic ser, int step);
    if (ser) begin
      if (step == 2) return 3'b001;
      if (step == 4) return 3'b010;
      if (step == 6) return 3'b100;
      return 3'b000;
    end
    if (step == 2) return 3'b001;
    if (step >= 6) return 3'b010;
    return 3'b000;
  endfunction

  function automatic bit m_ok(logic ser, logic sel, int step, logic [3:0] s);
    if (ser) begin
      case (step)
        1: return s[0] && s[1];
        2: return !s[0];
        3: return s[0];
        4: return !s[1];
        5: return s[1];
        6: return !s[1];
        default: return s[1];
      endcase
    end
    case (step)
      1: return s[0];
      2: return !s[0];
      3: return s[0];
      4: return sel ? !s[3] : !s[2];
      5: return s[1];
      6: return !s[1];
      7: return sel ? 1'b1 : s[2];
      default: return sel ? s[3] : 1'b1;
    endcase
  endfunction

  logic       m_busy, m_done, m_mode, m_sel;
  logic [2:0] m_drv;
  logic [7:0] m_status;
  logic [3:0] h1, h2, cur;
  int         m_step, m_cnt, m_settle;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_status = 0; m_drv = 0; m_mode = 0; m_sel = 0;
      m_step = 0; m_cnt = 0; m_settle = 0; h1 = 0; h2 = 0;
    end else begin
      cur = loop_fn(harness, m_drv, stuck0, stuck1, atn_open);
      m_done = 0;
      if (!m_busy) begin
        if (start_i) begin
          m_busy = 1; m_step = 1; m_status = 0; m_mode = mode_i;
          m_sel = sense_sel_i; m_settle = int'(settle_i); m_cnt = m_settle;
        end
      end else if (m_cnt > 0) begin
        m_cnt--;
      end else if (!m_ok(m_mode, m_sel, m_step, h2)) begin
        m_busy = 0; m_done = 1; m_status = 8'(m_step);
      end else if (m_step == (m_mode ? 7 : 8)) begin
        m_busy = 0; m_done = 1; m_status = 0;
      end else begin
        m_step++; m_cnt = m_settle;
      end
      m_drv = m_busy ? m_drive(m_mode, m_step) : 3'b000;
      h2 = h1; h1 = cur;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en && !fin) begin
      checks++;
      if (busy_o !== m_busy || done_o !== m_done || status_o !== m_status || drv_o !== m_drv) begin
        errors++;
        $display("FAIL R2 cycle compare: actual busy=%0b done=%0b status=%0d drv=%b expected busy=%0b done=%0b status=%0d drv=%b",
                 busy_o, done_o, status_o, drv_o, m_busy, m_done, m_status, m_drv);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_case(string tag, logic ser, logic sel, int settle, logic [3:0] s0,
                          logic [3:0] s1, logic ao, int exp, bit disturb);
    int cnt;
    int steps;
    harness = ser; stuck0 = s0; stuck1 = s1; atn_open = ao;
    mode_i = ser; sense_sel_i = sel; settle_i = 16'(settle);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cnt = 0;
    while (!done_o) begin
      if (busy_o) cnt++;
      if (disturb && cnt == 3) begin
        mode_i = ~mode_i; sense_sel_i = ~sense_sel_i; settle_i = 16'd0; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk({tag, " status"}, int'(status_o), exp);
    chk({tag, " busy_o high at done"}, int'(busy_o), 0);
    steps = (exp == 0) ? (ser ? 7 : 8) : exp;
    chk({"R2 step timing ", tag}, cnt, steps * (settle + 1));
    repeat (4) @(negedge clk);
    chk({"R9 status held idle ", tag}, int'(status_o), exp);
    chk({"R10 idle drive ", tag}, int'(drv_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mode_i = 1'b0; sense_sel_i = 1'b0; settle_i = 16'd3;
    harness = 1'b0; stuck0 = 4'h0; stuck1 = 4'h0; atn_open = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset busy", int'(busy_o), 0);
    chk("R1 reset done", int'(done_o), 0);
    chk("R9 reset status", int'(status_o), 0);
    chk("R10 reset drive", int'(drv_o), 0);
    cmp_en = 1;

    run_case("R3 R4 R5 R6 tape pass sel0", 0, 0, 3, 4'h0, 4'h0, 0, 0, 0);
    run_case("R6 tape pass sel1",          0, 1, 5, 4'h0, 4'h0, 0, 0, 0);
    run_case("R3 read stuck low",          0, 0, 2, 4'h1, 4'h0, 0, 1, 0);
    run_case("R3 R9 read stuck high",      0, 0, 3, 4'h0, 4'h1, 0, 2, 0);
    run_case("R4 mapped sense stuck high", 0, 0, 2, 4'h0, 4'h4, 0, 4, 0);
    run_case("R6 unselected sense ignored",0, 1, 2, 4'h0, 4'h4, 0, 0, 0);
    run_case("R4 motor readback low",      0, 0, 4, 4'h2, 4'h0, 0, 5, 0);
    run_case("R5 motor readback high",     0, 0, 2, 4'h0, 4'h2, 0, 6, 0);
    run_case("R6 mapped sense dead",       0, 0, 3, 4'h4, 4'h0, 0, 7, 0);
    run_case("R6 port sense dead",         0, 1, 3, 4'h8, 4'h0, 0, 8, 0);
    run_case("R6 step8 skipped sel0",      0, 0, 2, 4'h8, 4'h0, 0, 0, 0);
    run_case("R7 serial pass",             1, 0, 2, 4'h0, 4'h0, 0, 0, 0);
    run_case("R7 data-in stuck high",      1, 0, 3, 4'h0, 4'h1, 0, 2, 0);
    run_case("R7 clk-in stuck low",        1, 0, 2, 4'h2, 4'h0, 0, 1, 0);
    run_case("R8 attention link open",     1, 0, 2, 4'h0, 4'h0, 1, 6, 0);
    run_case("R10 serial upper bits",      1, 1, 2, 4'h0, 4'hC, 0, 0, 0);
    run_case("R11 R1 inputs changed mid-run", 1, 0, 2, 4'h0, 4'h0, 0, 0, 1);
    run_case("R2 long settle",             0, 0, 40, 4'h0, 4'h0, 0, 0, 0);

    fin = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule